// File: doc/BRIEF.md
# Programmable UART with Processor Register Port

This block is a byte-wide asynchronous serial transmitter and receiver that sits on a simple processor register bus. The host selects the block with a chip-select line. A read/not-write line sets the direction, and a 2-bit address picks one of four registers. Write data enters on `bus_wdata`. Read data leaves on `bus_rdata` together with an output enable, which lets the surrounding logic merge the two halves into one shared data bus.

A host-loaded 16-bit divisor produces a one-cycle tick at sixteen times the bit rate. The host can therefore hold a fixed line rate, such as 4800 or 9600 bit/s, whatever the system clock is. The divisor is the system clock divided by sixteen times the bit rate. The default after reset suits a 50 MHz clock at 9600 bit/s.

On the transmit side, the host writes a byte into a one-entry holding register. A shifter then frames that byte onto the serial line. On the receive side, a synchronized and oversampled front end rebuilds bytes from the line. It flags receive data available, overrun, framing and parity conditions. The transmit path uses a valid/ready rule for back-pressure. The host may present a byte only while `tx_ready` is high. A write made while `tx_ready` is low is dropped, so the host must poll `tx_ready` (port or status bit 0) before each write. The receive path has no back-pressure: a byte that is not read in time is replaced by the next one.

Top module: `prog_uart`

## Requirements
- R1: After reset, `ser_tx` is high, `tx_ready` is 1, `rx_avail` is 0, `bus_rdata_oe` is 0 and the status register reads 0x01.
- R2: The transmit frame is one low start bit, then the 8 data bits least significant first, then an optional parity bit, then one high stop bit. Each bit lasts 16 baud ticks, and the line rests high between frames. `par_mode` selects the parity: 2'b01 is even (the parity bit makes the total count of ones even), 2'b10 is odd, and 2'b00 or 2'b11 send no parity bit.
- R3: A write to address 0 (with `bus_cs`=1 and `bus_rd_nwr`=0) is accepted only while `tx_ready` is 1. After an accepted write, `tx_ready` is 0 in the next cycle. It returns to 1 once the shifter takes the byte, which is the cycle after that when the shifter is idle. A write made while `tx_ready` is 0 sends nothing.
- R4: A write to address 2 stages the low divisor byte. A write to address 3 supplies the high byte, applies the full 16-bit divisor and restarts the tick counter. The tick period is then divisor clocks (0 and 1 both give a tick every clock), so one serial bit lasts 16 × divisor clocks.
- R5: The serial input passes through two synchronizing flops. A falling edge starts a frame, and the start bit is confirmed if the input is still low at the 8th tick. Each later bit is sampled every 16 ticks after that. Once the stop bit is sampled, `rx_avail` goes to 1. A read of address 0 returns the byte and clears `rx_avail`.
- R6: If the input is back high at the 8th tick after a falling edge, the receiver returns to idle and no byte is reported.
- R7: If a byte completes while `rx_avail` is still 1, the new byte replaces the old one and status bit 2 (overrun) sets.
- R8: A stop bit sampled low sets status bit 3 (framing error), and the byte is still delivered.
- R9: With parity enabled, a received parity bit that does not match the rule of R2 sets status bit 4 (parity error).
- R10: `bus_rdata_oe` is 1 exactly when `bus_cs`=1 and `bus_rd_nwr`=1, and `bus_rdata` is 0 whenever it is 0. Address 1 reads the status register: bit 0 is `tx_ready`, bit 1 is `rx_avail`, bits 2 to 4 are as in R7 to R9, and bits 7 to 5 are 0. Reading status clears bits 2 to 4. Addresses 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip select; accesses count only while high |
| bus_rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data from the host |
| bus_rdata | output | 8 | Read data to the host, 0 when not enabled |
| bus_rdata_oe | output | 1 | Drive enable for the shared data bus |
| par_mode | input | 2 | Parity select: 00/11 none, 01 even, 10 odd |
| ser_rx | input | 1 | Asynchronous serial input |
| ser_tx | output | 1 | Serial output |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_avail | output | 1 | A received byte is waiting |

## Verification
The hardest situations to reach from the ports are those that depend on when the line moves relative to the free-running baud tick. Examples are a start pulse that dies before the 8th tick, and a second frame that lands while the first byte is still unread. The bench drives the serial input from its own bit-timed model, so it can shorten a start pulse to a few ticks and send two frames back to back without reading in between. It also corrupts the parity or stop bit on purpose. On the transmit side, it issues a third write while one byte is shifting and another is held, and checks that no extra frame appears on the line.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_STAT  = 2'd1,
    REG_DIVLO = 2'd2,
    REG_DIVHI = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam int ST_TXRDY = 0;
  localparam int ST_RXAV  = 1;
  localparam int ST_OVR   = 2;
  localparam int ST_FERR  = 3;
  localparam int ST_PERR  = 4;

  // parity bit for a byte: even when odd_sel=0, odd when odd_sel=1
  function automatic logic parity_of(input logic [BYTE_W-1:0] d, input logic odd_sel);
    return (^d) ^ odd_sel;
  endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud
  import uart_pkg::*;
#(
  parameter int unsigned DIV_RST = 326
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              tick
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_stage;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_stage <= '0;
      div_q    <= DIV_W'(DIV_RST);
      cnt      <= '0;
      tick     <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (lo_we) lo_stage <= wbyte;
      if (hi_we) begin
        div_q <= {wbyte, lo_stage};
        cnt   <= '0;
      end else if (({1'b0, cnt} + (DIV_W+1)'(1)) >= {1'b0, div_q}) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              busy,
  output logic              txd
);
  localparam int CW      = $clog2(OSR);
  localparam int FRAME_W = BYTE_W + 3;
  localparam int NW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sreg;
  logic [NW-1:0]      nleft;
  logic [CW-1:0]      tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '1;
      nleft <= '0;
      tcnt  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      sreg  <= {1'b1, par_en ? parity_of(ld_byte, par_odd) : 1'b1, ld_byte, 1'b0};
      nleft <= par_en ? NW'(FRAME_W) : NW'(FRAME_W - 1);
      tcnt  <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == CW'(OSR - 1)) begin
        tcnt <= '0;
        if (nleft == NW'(1)) begin
          busy <= 1'b0;
        end else begin
          nleft <= nleft - NW'(1);
          sreg  <= {1'b1, sreg[FRAME_W-1:1]};
        end
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end

  assign txd = busy ? sreg[0] : 1'b1;

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R2
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && nleft == NW'(1)) |-> txd);
  // R3
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_async,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ferr_o,
  output logic              perr_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(BYTE_W);

  logic              s1, s2, s3;
  rx_state_e         state;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bcnt;
  logic [BYTE_W-1:0] sh;
  logic              pbit, pen_l, podd_l;
  logic              at_mid, at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd_async;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign at_mid = tick && (tcnt == CW'(OSR/2 - 1));
  assign at_end = tick && (tcnt == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      tcnt   <= '0;
      bcnt   <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      pen_l  <= 1'b0;
      podd_l <= 1'b0;
      done   <= 1'b0;
      byte_o <= '0;
      ferr_o <= 1'b0;
      perr_o <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state != RX_IDLE && tick) tcnt <= tcnt + CW'(1);
      unique case (state)
        RX_IDLE: if (s3 && !s2) begin
          state  <= RX_START;
          tcnt   <= '0;
          pen_l  <= par_en;
          podd_l <= par_odd;
        end
        RX_START: if (at_mid) begin
          tcnt <= '0;
          bcnt <= '0;
          state <= s2 ? RX_IDLE : RX_DATA;
        end
        RX_DATA: if (at_end) begin
          sh   <= {s2, sh[BYTE_W-1:1]};
          bcnt <= bcnt + BW'(1);
          if (bcnt == BW'(BYTE_W - 1)) state <= pen_l ? RX_PAR : RX_STOP;
        end
        RX_PAR: if (at_end) begin
          pbit  <= s2;
          state <= RX_STOP;
        end
        RX_STOP: if (at_end) begin
          done   <= 1'b1;
          byte_o <= sh;
          ferr_o <= !s2;
          perr_o <= pen_l && (pbit != parity_of(sh, podd_l));
          state  <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R6
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && at_mid && s2) |=> (state == RX_IDLE && !done));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/prog_uart.sv
module prog_uart
  import uart_pkg::*;
#(
  parameter int unsigned DIV_RST = 326,
  parameter int unsigned OSR     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_rd_nwr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  input  logic [1:0]        par_mode,
  input  logic              ser_rx,
  output logic              ser_tx,
  output logic              tx_ready,
  output logic              rx_avail
);
  logic              wr_en, rd_en, tx_acc, tx_load, data_rd, stat_rd;
  logic              tick, tx_busy, par_en, par_odd;
  logic              rx_done, rx_ferr, rx_perr;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] hold_q, rx_data_q, status;
  logic              hold_full, ovr_q, ferr_q, perr_q;

  assign wr_en   = bus_cs && !bus_rd_nwr;
  assign rd_en   = bus_cs && bus_rd_nwr;
  assign tx_acc  = wr_en && (bus_addr == REG_DATA) && !hold_full;
  assign tx_load = hold_full && !tx_busy;
  assign data_rd = rd_en && (bus_addr == REG_DATA);
  assign stat_rd = rd_en && (bus_addr == REG_STAT);
  assign par_en  = (par_mode == 2'b01) || (par_mode == 2'b10);
  assign par_odd = (par_mode == 2'b10);

  uart_baud #(.DIV_RST(DIV_RST)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .lo_we (wr_en && bus_addr == REG_DIVLO),
    .hi_we (wr_en && bus_addr == REG_DIVHI),
    .wbyte (bus_wdata),
    .tick  (tick)
  );

  uart_tx #(.OSR(OSR)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (tx_load),
    .ld_byte (hold_q),
    .par_en  (par_en),
    .par_odd (par_odd),
    .busy    (tx_busy),
    .txd     (ser_tx)
  );

  uart_rx #(.OSR(OSR)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rxd_async (ser_rx),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .done      (rx_done),
    .byte_o    (rx_byte),
    .ferr_o    (rx_ferr),
    .perr_o    (rx_perr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (tx_acc) begin
      hold_q    <= bus_wdata;
      hold_full <= 1'b1;
    end else if (tx_load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_q <= '0;
      rx_avail  <= 1'b0;
      ovr_q     <= 1'b0;
      ferr_q    <= 1'b0;
      perr_q    <= 1'b0;
    end else begin
      ovr_q  <= (ovr_q  && !stat_rd) || (rx_done && rx_avail && !data_rd);
      ferr_q <= (ferr_q && !stat_rd) || (rx_done && rx_ferr);
      perr_q <= (perr_q && !stat_rd) || (rx_done && rx_perr);
      if (rx_done) begin
        rx_data_q <= rx_byte;
        rx_avail  <= 1'b1;
      end else if (data_rd) begin
        rx_avail <= 1'b0;
      end
    end
  end

  assign tx_ready = !hold_full;

  always_comb begin
    status           = '0;
    status[ST_TXRDY] = tx_ready;
    status[ST_RXAV]  = rx_avail;
    status[ST_OVR]   = ovr_q;
    status[ST_FERR]  = ferr_q;
    status[ST_PERR]  = perr_q;
  end

  assign bus_rdata_oe = rd_en;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (bus_addr)
        REG_DATA: bus_rdata = rx_data_q;
        REG_STAT: bus_rdata = status;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R3
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(bus_cs && !bus_rd_nwr && bus_addr == REG_DATA));
  // R5
  avail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_avail) |-> $past(rx_done));
  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_avail && rx_done));
  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_oe |-> (bus_rdata == '0));
endmodule

// File: tb/prog_uart_tb.sv
module prog_uart_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0;
  logic       bus_rd_nwr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       bus_rdata_oe;
  logic [1:0] pm = 2'b00;
  logic       rxd = 1'b1;
  logic       txd;
  logic       tx_ready;
  logic       rx_avail;

  int nvec = 0;
  int nfail = 0;
  int div_v = 326;
  int P = 326 * 16;
  bit finished = 1'b0;

  logic [10:0] txq[$];
  logic [10:0] mon_f;
  int          mon_nb;

  always #5 clk = ~clk;

  prog_uart u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cs       (bus_cs),
    .bus_rd_nwr   (bus_rd_nwr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_rdata_oe (bus_rdata_oe),
    .par_mode     (pm),
    .ser_rx       (rxd),
    .ser_tx       (txd),
    .tx_ready     (tx_ready),
    .rx_avail     (rx_avail)
  );

  function automatic bit par_on(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic logic par_val(input logic [7:0] d, input logic [1:0] m);
    return (m == 2'b10) ? ~(^d) : (^d);
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic [1:0] m);
    if (par_on(m)) return {1'b1, par_val(d, m), d, 1'b0};
    return {1'b0, 1'b1, d, 1'b0};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd_nwr = 1'b0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd_nwr = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_cs = 1'b0; bus_rd_nwr = 1'b0;
  endtask

  task automatic set_div(input int dv);
    bus_write(2'd2, dv[7:0]);
    bus_write(2'd3, dv[15:8]);
    div_v = dv;
    P = 16 * dv;
  endtask

  task automatic wait_frame(output bit got);
    int n = 0;
    while (txq.size() == 0 && n < 30 * P) begin
      @(negedge clk);
      n++;
    end
    got = (txq.size() != 0);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    @(negedge clk) rxd = 1'b0;
    repeat (P) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (P) @(negedge clk);
    end
    if (par_on(pm)) begin
      rxd = par_val(d, pm) ^ bad_par;
      repeat (P) @(negedge clk);
    end
    rxd = !bad_stop;
    repeat (P) @(negedge clk);
    rxd = 1'b1;
    repeat (P) @(negedge clk);
  endtask

  // serial line monitor for the transmit output
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        mon_f  = '0;
        mon_nb = par_on(pm) ? 11 : 10;
        repeat (P / 2) @(negedge clk);
        for (int i = 0; i < mon_nb; i++) begin
          mon_f[i] = txd;
          if (i < mon_nb - 1) repeat (P) @(negedge clk);
        end
        txq.push_back(mon_f);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R1-watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, d, d2;
    logic [10:0] f;
    bit got;
    int lowcnt;
    void'($urandom(32'h5A17));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ser_tx", txd, 1);
    chk("R1", "tx_ready", tx_ready, 1);
    chk("R1", "rx_avail", rx_avail, 0);
    chk("R1", "oe", bus_rdata_oe, 0);
    bus_read(2'd1, rd);
    chk("R1", "status", rd, 8'h01);

    // R10 bus release and write-only addresses
    bus_cs = 1'b0; bus_rd_nwr = 1'b1; bus_addr = 2'd1;
    #1 chk("R10", "oe no cs", bus_rdata_oe, 0);
    chk("R10", "rdata no cs", bus_rdata, 0);
    bus_cs = 1'b1; bus_rd_nwr = 1'b0;
    #1 chk("R10", "oe on write", bus_rdata_oe, 0);
    @(negedge clk);
    bus_cs = 1'b0;
    bus_read(2'd3, rd);
    chk("R10", "addr3 read", rd, 0);

    set_div(4);

    // R2 random transmit frames across parity modes
    for (int k = 0; k < 8; k++) begin
      pm = 2'(k % 4);
      d = 8'($urandom);
      if (k == 0) d = 8'h00;
      if (k == 1) d = 8'hFF;
      bus_write(2'd0, d);
      wait_frame(got);
      chk("R2", "frame seen", 32'(got), 1);
      if (got) begin
        f = txq.pop_front();
        chk("R2", "frame bits", f, exp_frame(d, pm));
      end
      repeat (P) @(negedge clk);
      chk("R2", "idle high", txd, 1);
    end

    // R3 holding register handshake, ignored write
    pm = 2'b00;
    bus_write(2'd0, 8'hA5);
    #1 chk("R3", "ready low after write", tx_ready, 0);
    @(negedge clk);
    #1 chk("R3", "ready back after load", tx_ready, 1);
    bus_write(2'd0, 8'h3C);
    #1 chk("R3", "ready low while held", tx_ready, 0);
    bus_write(2'd0, 8'hE7);
    #1 chk("R3", "ready still low", tx_ready, 0);
    wait_frame(got);
    if (got) f = txq.pop_front(); else f = '0;
    chk("R3", "first frame", f, exp_frame(8'hA5, 2'b00));
    wait_frame(got);
    if (got) f = txq.pop_front(); else f = '0;
    chk("R3", "second frame", f, exp_frame(8'h3C, 2'b00));
    repeat (3 * 11 * P) @(negedge clk);
    chk("R3", "no third frame", txq.size(), 0);
    chk("R3", "line idle", txd, 1);

    // R5 random received bytes
    for (int k = 0; k < 8; k++) begin
      pm = 2'(k % 4);
      d = 8'($urandom);
      send_rx(d, 1'b0, 1'b0);
      chk("R5", "rx_avail", rx_avail, 1);
      bus_read(2'd1, rd);
      chk("R5", "status", rd, 8'h03);
      bus_read(2'd0, rd);
      chk("R5", "data", rd, d);
      chk("R5", "avail cleared", rx_avail, 0);
    end

    // R6 false start pulse
    pm = 2'b00;
    @(negedge clk) rxd = 1'b0;
    repeat (4 * div_v) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * P) @(negedge clk);
    bus_read(2'd1, rd);
    chk("R6", "no byte after glitch", rd, 8'h01);
    send_rx(8'h96, 1'b0, 1'b0);
    bus_read(2'd0, rd);
    chk("R6", "frame after glitch", rd, 8'h96);

    // R8 framing error
    send_rx(8'h5B, 1'b0, 1'b1);
    bus_read(2'd1, rd);
    chk("R8", "status ferr", rd, 8'h0B);
    bus_read(2'd0, rd);
    chk("R8", "data kept", rd, 8'h5B);
    bus_read(2'd1, rd);
    chk("R8", "ferr cleared", rd, 8'h01);

    // R9 parity error
    pm = 2'b01;
    send_rx(8'hC4, 1'b1, 1'b0);
    bus_read(2'd1, rd);
    chk("R9", "status perr even", rd, 8'h13);
    bus_read(2'd0, rd);
    chk("R9", "data", rd, 8'hC4);
    pm = 2'b10;
    send_rx(8'h17, 1'b1, 1'b0);
    bus_read(2'd1, rd);
    chk("R9", "status perr odd", rd, 8'h13);
    bus_read(2'd0, rd);

    // R7 overrun
    pm = 2'b00;
    d = 8'($urandom);
    d2 = ~d;
    send_rx(d, 1'b0, 1'b0);
    send_rx(d2, 1'b0, 1'b0);
    bus_read(2'd1, rd);
    chk("R7", "status ovr", rd, 8'h07);
    bus_read(2'd0, rd);
    chk("R7", "newest byte", rd, d2);
    bus_read(2'd1, rd);
    chk("R7", "ovr cleared", rd, 8'h01);

    // R4 divisor change
    set_div(8);
    bus_write(2'd0, 8'h6D);
    lowcnt = 0;
    while (txd !== 1'b0 && lowcnt < 1000) begin @(negedge clk); lowcnt++; end
    lowcnt = 0;
    while (txd === 1'b0 && lowcnt < 4 * P) begin @(negedge clk); lowcnt++; end
    chk("R4", "start bit length", 32'(lowcnt >= P - div_v && lowcnt <= P), 1);
    wait_frame(got);
    if (got) f = txq.pop_front(); else f = '0;
    chk("R4", "frame at new rate", f, exp_frame(8'h6D, 2'b00));
    send_rx(8'hB2, 1'b0, 1'b0);
    bus_read(2'd0, rd);
    chk("R4", "rx at new rate", rd, 8'hB2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule